// File: doc/BRIEF.md
# Link Diagnostic Loopback Controller

This block decides which data path a point-to-point serial link endpoint uses for its receive outputs and its transmit stream. It chooses among normal operation, local loopback (the endpoint's own transmit data is turned straight back to its receive outputs), remote loopback as initiator (a request is placed in the outgoing frame so the far end echoes the data back), and remote loopback as responder (the endpoint echoes what it receives because the far end asked for it).

Line coding, clock recovery and framing sit outside the block. They are represented by two strobes: one marks a valid incoming frame, together with the far-end request bit decoded from it, and one marks the frame boundary at which the data path may switch. The far-end request bit is filtered: it must agree across a set number of consecutive valid frames before the block acts on it. Every mode change waits for a boundary strobe, so no frame is ever split across two paths.

Top module: `link_loop_ctrl`

## Requirements
- R1: After a synchronous reset, the mode output is 2'b00 and rx_loop_o, tx_echo_o and req_flag_o are all 0.
- R2: The mode output encodes 2'b00 normal, 2'b01 local loopback, 2'b10 remote initiator and 2'b11 remote responder. rx_loop_o is 1 only in local loopback, req_flag_o only as remote initiator and tx_echo_o only as remote responder.
- R3: If local loopback and near-end remote loopback are both requested at a boundary, the block enters local loopback.
- R4: Local loopback is entered at a boundary whatever the level of carrier detect.
- R5: The mode changes only on the clock edge where frm_bound_i is high. Requests and far-end flags that arrive between boundaries have no effect until the next boundary.
- R6: The far-end request counts as present only once it has been seen set in CONFIRM_FRAMES (default 2) consecutive valid frames. A single set frame, or set frames separated by a clear one, does not lead to the responder mode.
- R7: Once present, the far-end request counts as gone only after CONFIRM_FRAMES consecutive valid frames with the bit clear. A single clear frame leaves the responder mode in place.
- R8: While the far-end request counts as present and local loopback is not requested, a near-end remote request is ignored: the mode stays 2'b11 and req_flag_o stays 0.
- R9: The remote initiator mode is entered and kept only while the near-end remote request and carrier detect are both high at a boundary. At the first boundary where either is low, the block falls back to normal (or to a higher-priority mode).
- R10: A local loopback request overrides the responder mode. Far-end flags received during local loopback are still filtered, so on release the block enters the responder mode if the far-end request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_req_i | input | 1 | Local loopback request |
| rmt_req_i | input | 1 | Near-end request to start remote loopback |
| cd_i | input | 1 | Carrier detect / link lock status |
| frm_valid_i | input | 1 | One-cycle strobe: a valid frame has arrived |
| far_req_i | input | 1 | Far-end loopback request bit of that frame, sampled with frm_valid_i |
| frm_bound_i | input | 1 | One-cycle frame boundary strobe; mode changes happen here |
| mode_o | output | 2 | Current mode: 00 normal, 01 local, 10 remote initiator, 11 remote responder |
| rx_loop_o | output | 1 | Receive outputs take local transmit data instead of line payload |
| tx_echo_o | output | 1 | Transmit path sends received data back to the far end |
| req_flag_o | output | 1 | Remote loopback request bit for the outgoing frame |

## Verification
The hardest situation to reach is a far-end request that becomes present or absent while the block cannot act on it: during local loopback, or between boundaries. The bench drives valid-frame strobes without a boundary strobe to show that the filter state moves while the mode holds. It also sends far-end frames during local loopback and then releases the local request, showing that the responder mode follows straight away. Broken streaks (set, clear, set) are sent so that one stray frame cannot trip the filter.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [1:0] {
        MODE_NORM  = 2'b00,
        MODE_LOCAL = 2'b01,
        MODE_RINIT = 2'b10,
        MODE_RRESP = 2'b11
    } lpc_mode_e;

    typedef struct packed {
        logic rx_loop;
        logic tx_echo;
        logic req_flag;
    } lpc_path_t;

    // Fixed arbitration: local > responder > initiator > normal.
    function automatic lpc_mode_e pick_mode(
        input logic loc_req,
        input logic far_seen,
        input logic rmt_req,
        input logic cd
    );
        if (loc_req)             return MODE_LOCAL;
        else if (far_seen)       return MODE_RRESP;
        else if (rmt_req && cd)  return MODE_RINIT;
        else                     return MODE_NORM;
    endfunction

    function automatic lpc_path_t decode_path(input lpc_mode_e m);
        lpc_path_t p;
        p.rx_loop  = (m == MODE_LOCAL);
        p.tx_echo  = (m == MODE_RRESP);
        p.req_flag = (m == MODE_RINIT);
        return p;
    endfunction

endpackage

// File: rtl/lpc_far_filter.sv
module lpc_far_filter #(
    parameter int CONFIRM_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frm_valid_i,
    input  logic far_req_i,
    output logic far_seen_o
);
    localparam int CW = (CONFIRM_FRAMES > 1) ? $clog2(CONFIRM_FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONFIRM_FRAMES - 1);

    logic          seen_q;
    logic [CW-1:0] streak_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q   <= 1'b0;
            streak_q <= '0;
        end else if (frm_valid_i) begin
            if (far_req_i == seen_q) begin
                streak_q <= '0;
            end else if (streak_q == LAST) begin
                seen_q   <= far_req_i;
                streak_q <= '0;
            end else begin
                streak_q <= streak_q + 1'b1;
            end
        end
    end

    assign far_seen_o = seen_q;

    // R6 / R7: the filtered flag moves only on a valid frame carrying the new value
    a_r6_change_on_frame: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$stable(seen_q) |-> $past(frm_valid_i) && ($past(far_req_i) == seen_q));

    // R7: a frame agreeing with the current state never flips it
    a_r7_agree_holds: assert property (@(posedge clk) disable iff (rst)
        frm_valid_i && (far_req_i == seen_q) |=> $stable(seen_q));

endmodule

// File: rtl/lpc_mode_reg.sv
module lpc_mode_reg
    import lpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frm_bound_i,
    input  logic      loc_req_i,
    input  logic      rmt_req_i,
    input  logic      cd_i,
    input  logic      far_seen_i,
    output lpc_mode_e mode_o
);
    lpc_mode_e mode_q;
    lpc_mode_e target;

    always_comb target = pick_mode(loc_req_i, far_seen_i, rmt_req_i, cd_i);

    always_ff @(posedge clk) begin
        if (rst)              mode_q <= MODE_NORM;
        else if (frm_bound_i) mode_q <= target;
    end

    assign mode_o = mode_q;

    // R5: mode moves only on a boundary edge
    a_r5_bound_only: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$stable(mode_q) |-> $past(frm_bound_i));

    // R3 / R4: a local request at a boundary always yields local loopback
    a_r3_local_wins: assert property (@(posedge clk) disable iff (rst)
        frm_bound_i && loc_req_i |=> mode_q == MODE_LOCAL);

    // R8: near-end remote request ignored while far-end request present
    a_r8_resp_blocks: assert property (@(posedge clk) disable iff (rst)
        frm_bound_i && far_seen_i && !loc_req_i |=> mode_q == MODE_RRESP);

    // R9: initiator never entered or kept without carrier or request
    a_r9_init_needs_cd: assert property (@(posedge clk) disable iff (rst)
        frm_bound_i && !(cd_i && rmt_req_i) |=> mode_q != MODE_RINIT);

endmodule

// File: rtl/lpc_path_dec.sv
module lpc_path_dec
    import lpc_pkg::*;
(
    input  lpc_mode_e mode_i,
    output logic      rx_loop_o,
    output logic      tx_echo_o,
    output logic      req_flag_o
);
    lpc_path_t path;

    always_comb path = decode_path(mode_i);

    assign rx_loop_o  = path.rx_loop;
    assign tx_echo_o  = path.tx_echo;
    assign req_flag_o = path.req_flag;

    // R2: at most one path override active
    always_comb begin
        a_r2_one_path: assert ($onehot0({rx_loop_o, tx_echo_o, req_flag_o}));
    end

endmodule

// File: rtl/link_loop_ctrl.sv
module link_loop_ctrl
    import lpc_pkg::*;
#(
    parameter int CONFIRM_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       loc_req_i,
    input  logic       rmt_req_i,
    input  logic       cd_i,
    input  logic       frm_valid_i,
    input  logic       far_req_i,
    input  logic       frm_bound_i,
    output logic [1:0] mode_o,
    output logic       rx_loop_o,
    output logic       tx_echo_o,
    output logic       req_flag_o
);
    logic      far_seen;
    lpc_mode_e mode;

    lpc_far_filter #(.CONFIRM_FRAMES(CONFIRM_FRAMES)) u_filt (
        .clk         (clk),
        .rst         (rst),
        .frm_valid_i (frm_valid_i),
        .far_req_i   (far_req_i),
        .far_seen_o  (far_seen)
    );

    lpc_mode_reg u_mode (
        .clk         (clk),
        .rst         (rst),
        .frm_bound_i (frm_bound_i),
        .loc_req_i   (loc_req_i),
        .rmt_req_i   (rmt_req_i),
        .cd_i        (cd_i),
        .far_seen_i  (far_seen),
        .mode_o      (mode)
    );

    lpc_path_dec u_dec (
        .mode_i     (mode),
        .rx_loop_o  (rx_loop_o),
        .tx_echo_o  (tx_echo_o),
        .req_flag_o (req_flag_o)
    );

    assign mode_o = mode;

    // R1: reset puts the block in normal mode
    a_r1_reset_norm: assert property (@(posedge clk)
        rst |=> mode_o == 2'b00);

endmodule

// File: tb/sim_link_loop_ctrl.sv
module sim_link_loop_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       loc_req = 1'b0, rmt_req = 1'b0, cd = 1'b0;
    logic       frm_valid = 1'b0, far_req = 1'b0, frm_bound = 1'b0;
    logic [1:0] mode;
    logic       rx_loop, tx_echo, req_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    link_loop_ctrl #(.CONFIRM_FRAMES(2)) u0 (
        .clk(clk), .rst(rst),
        .loc_req_i(loc_req), .rmt_req_i(rmt_req), .cd_i(cd),
        .frm_valid_i(frm_valid), .far_req_i(far_req), .frm_bound_i(frm_bound),
        .mode_o(mode), .rx_loop_o(rx_loop), .tx_echo_o(tx_echo), .req_flag_o(req_flag)
    );

    // expected {mode, rx_loop, tx_echo, req_flag} from the R2 encoding
    function automatic logic [4:0] expect_of(input logic [1:0] m);
        case (m)
            2'b01:   return {m, 3'b100};
            2'b10:   return {m, 3'b001};
            2'b11:   return {m, 3'b010};
            default: return {m, 3'b000};
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] exp_mode);
        logic [4:0] act, exp;
        act = {mode, rx_loop, tx_echo, req_flag};
        exp = expect_of(exp_mode);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // valid frame followed by a boundary; returns at a negedge after the update
    task automatic send_frame(input logic f);
        @(negedge clk); frm_valid = 1'b1; far_req = f;
        @(negedge clk); frm_valid = 1'b0; far_req = 1'b0; frm_bound = 1'b1;
        @(negedge clk); frm_bound = 1'b0;
    endtask

    task automatic valid_only(input logic f);
        @(negedge clk); frm_valid = 1'b1; far_req = f;
        @(negedge clk); frm_valid = 1'b0; far_req = 1'b0;
    endtask

    task automatic bound_only();
        @(negedge clk); frm_bound = 1'b1;
        @(negedge clk); frm_bound = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", 2'b00);
    endtask

    task automatic t_local_cd_low();
        cd = 1'b0; loc_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 no boundary yet", 2'b00);
        bound_only();
        check("R4 local with cd low", 2'b01);
        loc_req = 1'b0;
        bound_only();
        check("R2 back to normal", 2'b00);
    endtask

    task automatic t_concurrent();
        cd = 1'b1; loc_req = 1'b1; rmt_req = 1'b1;
        bound_only();
        check("R3 local beats remote", 2'b01);
        loc_req = 1'b0;
        bound_only();
        check("R9 initiator entered", 2'b10);
        cd = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 initiator held until boundary", 2'b10);
        bound_only();
        check("R9 cd low drops initiator", 2'b00);
        cd = 1'b1;
        bound_only();
        check("R9 initiator again", 2'b10);
        rmt_req = 1'b0;
        bound_only();
        check("R9 request low drops initiator", 2'b00);
    endtask

    task automatic t_far_enter();
        send_frame(1'b1);
        check("R6 single set frame", 2'b00);
        send_frame(1'b0);
        send_frame(1'b1);
        check("R6 broken streak", 2'b00);
        send_frame(1'b1);
        check("R6 two set frames", 2'b11);
        send_frame(1'b0);
        check("R7 single clear frame", 2'b11);
        send_frame(1'b0);
        check("R7 two clear frames", 2'b00);
    endtask

    task automatic t_between_bounds();
        valid_only(1'b1);
        valid_only(1'b1);
        check("R5 far present, no boundary", 2'b00);
        bound_only();
        check("R6 responder on boundary", 2'b11);
    endtask

    task automatic t_block();
        rmt_req = 1'b1; cd = 1'b1;
        bound_only();
        check("R8 remote request ignored", 2'b11);
        send_frame(1'b0);
        check("R8 still responder", 2'b11);
        send_frame(1'b1);
        send_frame(1'b0);
        check("R7 broken clear streak", 2'b11);
        send_frame(1'b0);
        check("R9 initiator after far release", 2'b10);
        rmt_req = 1'b0;
        bound_only();
        check("R9 normal", 2'b00);
    endtask

    task automatic t_local_over_resp();
        loc_req = 1'b1;
        bound_only();
        check("R10 local entered", 2'b01);
        send_frame(1'b1);
        send_frame(1'b1);
        check("R10 local holds over far request", 2'b01);
        loc_req = 1'b0;
        bound_only();
        check("R10 responder after local release", 2'b11);
        loc_req = 1'b1;
        bound_only();
        check("R10 local overrides responder", 2'b01);
        send_frame(1'b0);
        send_frame(1'b0);
        loc_req = 1'b0;
        bound_only();
        check("R10 far cleared during local", 2'b00);
    endtask

    initial begin
        t_reset();
        t_local_cd_low();
        t_concurrent();
        t_far_enter();
        t_between_bounds();
        t_block();
        t_local_over_resp();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule